// File: doc/BRIEF.md
# Idle-Timeout Power-Zone Controller

This block decides, zone by zone, whether a switchable region of a processor core (a vector register file, a crypto engine and the like) should be powered. Each zone keeps a count of the clock cycles since its last use. The count stops at all-ones rather than wrapping. Software sets a per-zone compare value. The zone is asked to turn off once the compare value is strictly below the idle count, and is asked to be on in every other case. A use request always asks for power. When a zone goes from off to on, the idle count it had just before that moment is kept in a per-zone previous-count register. Software can read that value to tune the timeout.

A use strobe that reaches a zone which is not usable sets a sticky per-zone fault flag. A zone is not usable when it is powered off, or when it is powered but its power-good input is still low. Software clears the flag by writing one to it. Software reaches the counters, the compare values, the previous counts and the status through a privileged register port. That port has no back-pressure: it takes an access in every cycle that `bus_en` is high. A read answers on the next cycle with `bus_rvalid`. The data bus never stalls.

Top module: `pwrzone_ctrl`

## Requirements
- R1: After reset, every `pwr_en` bit is 1 and every `fault` bit is 0. Every compare register holds 10000, and every idle counter and previous-count register holds 0.
- R2: A zone's idle counter rises by one on each clock edge at which that zone's `use_req` is low and no write or wake-up touches it.
- R3: On every edge at which `use_req` is high, the zone's idle counter becomes 0.
- R4: The idle counter stops at 0xFFFFFFFF and never wraps to zero by counting.
- R5: `pwr_en` is registered. After an edge it equals 0 exactly when, before that edge, the compare value was strictly less than the idle counter and `use_req` was low.
- R6: A compare value of 0xFFFFFFFF keeps `pwr_en` at 1 even when the counter is saturated.
- R7: With a compare value of 0, an idle zone turns off. It stays on while `use_req` is held, stays on for the first edge after release, and turns off at the second edge.
- R8: A use request to a zone whose `pwr_en` is 0 raises `pwr_en` at that edge. The counter value from before that edge is stored in the previous-count register, and the counter is cleared.
- R9: `use_req` sets `fault` when `pwr_en` or `pwr_good` is low for that zone. Writing 1 to status bit 0 clears it, and setting the flag wins over clearing it.
- R10: With `bus_priv` low, a write changes no register and a read returns 0.
- R11: The word address is zone*4 + field, with field 0 for the counter, 1 for compare, 2 for previous count and 3 for status. Status bit 0 is fault, bit 1 is `pwr_en` and bit 2 is `pwr_good`.
- R12: Every read access produces `bus_rvalid` = 1 with its data one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_req | input | NZONES | Per-zone use strobe |
| pwr_good | input | NZONES | Per-zone power-good from the switch |
| pwr_en | output | NZONES | Per-zone power request |
| fault | output | NZONES | Sticky per-zone fault flag |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | ADDR_W | Word address, zone*4 + field |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, one cycle after the access |
| bus_rvalid | output | 1 | Read data valid |

## Verification
The idle-count compare is driven in four ways:
- Free counting after a counter write checks exact cycle counts.
- A held use strobe tells clearing apart from counting.
- A compare of 5 is stepped past, which shows the strict-less-than edge: the zone is on at count 5 and off at count 6.
- Compare values of zero and all-ones, the latter with a counter preset next to saturation, separate immediate shutdown from pinning the zone on.

Wake-up by a use strobe is checked through the stored previous count. Fault raising is checked both with the power off and with the power on but power-good low. Privilege gating is checked on reads, writes and fault clearing.

// File: rtl/pzc_pkg.sv
`timescale 1ns/1ps
package pzc_pkg;
  typedef enum logic [1:0] {
    FLD_CNT  = 2'd0,
    FLD_CMP  = 2'd1,
    FLD_PREV = 2'd2,
    FLD_STAT = 2'd3
  } fld_e;

  localparam int STAT_FAULT = 0;
  localparam int STAT_PEN   = 1;
  localparam int STAT_PGOOD = 2;
  localparam int STAT_W     = 3;
endpackage

// File: rtl/pzc_zone.sv
`timescale 1ns/1ps
module pzc_zone
  import pzc_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int DEF_CMP = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_req,
  input  logic             pwr_good,
  input  logic             wr_en,
  input  logic [1:0]       wr_fld,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic [CNT_W-1:0] prev_o,
  output logic             fault_o,
  output logic             pwr_en_o
);
  localparam logic [CNT_W-1:0] CMAX    = '1;
  localparam logic [CNT_W-1:0] CMP_RST = CNT_W'(DEF_CMP);

  logic [CNT_W-1:0] cnt_q, cmp_q, prev_q;
  logic             pen_q, fault_q;
  logic             wr_cnt, wr_cmp, wr_prev, wr_stat;
  logic             on_req, wake, usable;

  assign wr_cnt  = wr_en && (wr_fld == FLD_CNT);
  assign wr_cmp  = wr_en && (wr_fld == FLD_CMP);
  assign wr_prev = wr_en && (wr_fld == FLD_PREV);
  assign wr_stat = wr_en && (wr_fld == FLD_STAT);

  assign on_req = use_req || !(cmp_q < cnt_q);
  assign wake   = on_req && !pen_q;
  assign usable = pen_q && pwr_good;

  always_ff @(posedge clk) begin
    if (!rst_n) pen_q <= 1'b1;
    else        pen_q <= on_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (wr_cnt)           cnt_q <= wr_data;
    else if (wake || use_req)  cnt_q <= '0;
    else if (cnt_q != CMAX)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       prev_q <= '0;
    else if (wake)    prev_q <= cnt_q;
    else if (wr_prev) prev_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cmp_q <= CMP_RST;
    else if (wr_cmp) cmp_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           fault_q <= 1'b0;
    else if (use_req && !usable)          fault_q <= 1'b1;
    else if (wr_stat && wr_data[STAT_FAULT]) fault_q <= 1'b0;
  end

  assign cnt_o    = cnt_q;
  assign cmp_o    = cmp_q;
  assign prev_o   = prev_q;
  assign fault_o  = fault_q;
  assign pwr_en_o = pen_q;

  // R3
  use_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_req && !wr_cnt) |=> (cnt_o == '0));

  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CMAX && !use_req && !wr_cnt && pwr_en_o) |=> (cnt_o == CMAX));

  // R5
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_o < cnt_o && !use_req) |=> !pwr_en_o);

  // R8
  wake_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en_o && use_req) |=> (pwr_en_o && prev_o == $past(cnt_o)));

  // R9
  fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_req && !(pwr_en_o && pwr_good)) |=> fault_o);
endmodule

// File: rtl/pzc_regif.sv
`timescale 1ns/1ps
module pzc_regif
  import pzc_pkg::*;
#(
  parameter int NZONES = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_en,
  input  logic                          bus_we,
  input  logic                          bus_priv,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [CNT_W-1:0]              bus_wdata,
  input  logic [NZONES-1:0][CNT_W-1:0]  cnt_a,
  input  logic [NZONES-1:0][CNT_W-1:0]  cmp_a,
  input  logic [NZONES-1:0][CNT_W-1:0]  prev_a,
  input  logic [NZONES-1:0][STAT_W-1:0] stat_a,
  output logic [NZONES-1:0]             zone_wr,
  output logic [1:0]                    wr_fld,
  output logic [CNT_W-1:0]              wr_data,
  output logic [CNT_W-1:0]              bus_rdata,
  output logic                          bus_rvalid
);
  localparam int ZB = ADDR_W - 2;

  logic [ZB-1:0]    zidx;
  logic [1:0]       fld;
  logic             hit;
  logic [CNT_W-1:0] rd_mux;

  assign zidx = bus_addr[ADDR_W-1:2];
  assign fld  = bus_addr[1:0];
  assign hit  = int'(zidx) < NZONES;

  assign wr_fld  = fld;
  assign wr_data = bus_wdata;

  for (genvar z = 0; z < NZONES; z++) begin : g_dec
    assign zone_wr[z] = bus_en && bus_we && bus_priv && (int'(zidx) == z);
  end

  always_comb begin
    rd_mux = '0;
    for (int z = 0; z < NZONES; z++) begin
      if (int'(zidx) == z) begin
        unique case (fld)
          FLD_CNT:  rd_mux = cnt_a[z];
          FLD_CMP:  rd_mux = cmp_a[z];
          FLD_PREV: rd_mux = prev_a[z];
          default:  rd_mux = CNT_W'(stat_a[z]);
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_en && !bus_we;
      bus_rdata  <= (bus_en && !bus_we && bus_priv && hit) ? rd_mux : '0;
    end
  end

  // R12
  rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we) |=> bus_rvalid);

  // R10
  unpriv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !bus_priv) |=> (bus_rdata == '0));

  // R10
  unpriv_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_priv) |-> (zone_wr == '0));
endmodule

// File: rtl/pwrzone_ctrl.sv
`timescale 1ns/1ps
module pwrzone_ctrl
  import pzc_pkg::*;
#(
  parameter int NZONES  = 4,
  parameter int CNT_W   = 32,
  parameter int DEF_CMP = 10000,
  parameter int ADDR_W  = ((NZONES > 1) ? $clog2(NZONES) : 1) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NZONES-1:0] use_req,
  input  logic [NZONES-1:0] pwr_good,
  output logic [NZONES-1:0] pwr_en,
  output logic [NZONES-1:0] fault,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              bus_rvalid
);
  logic [NZONES-1:0][CNT_W-1:0]  cnt_a, cmp_a, prev_a;
  logic [NZONES-1:0][STAT_W-1:0] stat_a;
  logic [NZONES-1:0]             zone_wr;
  logic [1:0]                    wr_fld;
  logic [CNT_W-1:0]              wr_data;

  pzc_regif #(
    .NZONES(NZONES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_regif (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_priv(bus_priv),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cnt_a(cnt_a), .cmp_a(cmp_a), .prev_a(prev_a), .stat_a(stat_a),
    .zone_wr(zone_wr), .wr_fld(wr_fld), .wr_data(wr_data),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  for (genvar z = 0; z < NZONES; z++) begin : g_zone
    pzc_zone #(
      .CNT_W(CNT_W), .DEF_CMP(DEF_CMP)
    ) u_zone (
      .clk(clk), .rst_n(rst_n),
      .use_req(use_req[z]), .pwr_good(pwr_good[z]),
      .wr_en(zone_wr[z]), .wr_fld(wr_fld), .wr_data(wr_data),
      .cnt_o(cnt_a[z]), .cmp_o(cmp_a[z]), .prev_o(prev_a[z]),
      .fault_o(fault[z]), .pwr_en_o(pwr_en[z])
    );
    assign stat_a[z][STAT_FAULT] = fault[z];
    assign stat_a[z][STAT_PEN]   = pwr_en[z];
    assign stat_a[z][STAT_PGOOD] = pwr_good[z];
  end
endmodule

// File: tb/sim_pwrzone_ctrl.sv
`timescale 1ns/1ps
module sim_pwrzone_ctrl;
  localparam int NZ = 4;
  localparam int CW = 32;
  localparam int AW = 4;
  localparam int F_CNT = 0, F_CMP = 1, F_PREV = 2, F_STAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NZ-1:0] use_req = '0;
  logic [NZ-1:0] pg_hold = '0;
  logic [NZ-1:0] pwr_good, pwr_en, fault;
  logic          bus_en = 1'b0, bus_we = 1'b0, bus_priv = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic          bus_rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign pwr_good = pwr_en & ~pg_hold;

  pwrzone_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .use_req(use_req), .pwr_good(pwr_good),
    .pwr_en(pwr_en), .fault(fault), .bus_en(bus_en), .bus_we(bus_we),
    .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input int zone, input int fld, input logic [CW-1:0] d, input bit priv);
    bus_en = 1'b1; bus_we = 1'b1; bus_priv = priv;
    bus_addr = AW'(zone * 4 + fld); bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_priv = 1'b0;
  endtask

  task automatic bus_rd(input int zone, input int fld, input bit priv, output logic [CW-1:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_priv = priv;
    bus_addr = AW'(zone * 4 + fld);
    @(negedge clk);
    bus_en = 1'b0; bus_priv = 1'b0;
    check("R12 rvalid", CW'(bus_rvalid), 1);
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [CW-1:0] d;
    check("R1 pwr_en", CW'(pwr_en), 32'hF);
    check("R1 fault", CW'(fault), 0);
    bus_rd(0, F_CMP, 1, d);  check("R1 cmp", d, 10000);
    bus_rd(2, F_PREV, 1, d); check("R1 prev", d, 0);
  endtask

  task automatic t_count();
    logic [CW-1:0] d;
    bus_wr(1, F_CNT, 0, 1);
    idle(10);
    bus_rd(1, F_CNT, 1, d); check("R2 count", d, 10);
    use_req[1] = 1'b1; idle(3); use_req[1] = 1'b0;
    idle(4);
    bus_rd(1, F_CNT, 1, d); check("R3 cleared by use", d, 4);
  endtask

  task automatic t_saturate();
    logic [CW-1:0] d;
    bus_wr(2, F_CMP, 32'hFFFF_FFFF, 1);
    bus_wr(2, F_CNT, 32'hFFFF_FFFE, 1);
    idle(3);
    bus_rd(2, F_CNT, 1, d); check("R4 saturate", d, 32'hFFFF_FFFF);
    check("R6 pinned on", CW'(pwr_en[2]), 1);
  endtask

  task automatic t_priv();
    logic [CW-1:0] d;
    bus_rd(2, F_CMP, 0, d); check("R10 unpriv read", d, 0);
    bus_wr(2, F_CMP, 7, 0);
    bus_rd(2, F_CMP, 1, d); check("R10 unpriv write ignored", d, 32'hFFFF_FFFF);
    check("R10 zone stays on", CW'(pwr_en[2]), 1);
  endtask

  task automatic t_strict();
    logic [CW-1:0] d;
    bus_wr(3, F_CNT, 0, 1);
    bus_wr(3, F_CMP, 5, 1);
    idle(5);
    check("R5 on at count==cmp", CW'(pwr_en[3]), 1);
    idle(1);
    check("R5 off past cmp", CW'(pwr_en[3]), 0);
    use_req[3] = 1'b1; idle(1); use_req[3] = 1'b0;
    check("R8 wake", CW'(pwr_en[3]), 1);
    check("R9 fault when off", CW'(fault[3]), 1);
    bus_rd(3, F_PREV, 1, d); check("R8 prev snapshot", d, 7);
  endtask

  task automatic t_zero();
    bus_wr(0, F_CMP, 0, 1);
    idle(1);
    check("R7 off when idle", CW'(pwr_en[0]), 0);
    use_req[0] = 1'b1; idle(3); use_req[0] = 1'b0;
    check("R7 on while used", CW'(pwr_en[0]), 1);
    idle(1);
    check("R7 on first edge after use", CW'(pwr_en[0]), 1);
    idle(1);
    check("R7 off second edge", CW'(pwr_en[0]), 0);
    bus_wr(0, F_STAT, 1, 1);
    check("R9 W1C clear", CW'(fault[0]), 0);
  endtask

  task automatic t_pgood();
    logic [CW-1:0] d;
    pg_hold[1] = 1'b1;
    use_req[1] = 1'b1; idle(1); use_req[1] = 1'b0;
    check("R9 fault when not good", CW'(fault[1]), 1);
    bus_wr(1, F_STAT, 1, 0);
    check("R10 unpriv clear ignored", CW'(fault[1]), 1);
    bus_rd(1, F_STAT, 1, d); check("R11 status fault+pen", d, 3);
    bus_wr(1, F_STAT, 1, 1);
    bus_rd(1, F_STAT, 1, d); check("R11 status pen only", d, 2);
    pg_hold[1] = 1'b0;
    idle(1);
    bus_rd(1, F_STAT, 1, d); check("R11 status pen+good", d, 6);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_saturate();
    t_priv();
    t_strict();
    t_zero();
    t_pgood();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule